// File: doc/BRIEF.md
# Shared-Slave Zero-Wait Arbiter

This block lets several bus masters share one slave device. Every link uses a protocol in which a command (read or write strobe, address, write data) is valid for exactly one cycle. The slave reports progress through a two-bit countdown that gives the remaining cycles, where 0 means done and 3 means three or more. Toward each master the arbiter looks like a slave. Toward the shared device it looks like a master.

The protocol has no request/grant handshake, and a master never repeats a command. For this reason the arbiter forwards a command to the slave in the same cycle it arrives whenever the slave's countdown is 0. Commands that lose arbitration, or that arrive while the slave is busy, are captured. They are later issued by fixed priority, with master 0 first.

A master that is waiting sees the countdown held at 3. A master that is being served sees the slave's countdown passed through. Every other master sees 0. Each master keeps its own copy of the last read result, so a result stays valid on that master's port until its next read completes.

Top module: `shared_slave_arbiter`

## Requirements
- R1: After reset every master countdown reads 0, every master read-data port reads 0, and no read or write strobe is driven to the slave.
- R2: When the slave countdown is 0 and no higher-priority command is waiting, a master's command appears on the slave port in the same cycle it is presented. There is no added latency.
- R3: Among waiting and newly presented commands, the one from the lowest-numbered master is issued. At most one command is issued per cycle, and only while the slave countdown is 0.
- R4: A command that is not issued at once is stored with its direction, address and write data, and is issued later unchanged. No more than N_MST-1 commands are stored at any time.
- R5: A master whose command is stored and not yet issued sees a countdown of 3.
- R6: From the cycle after its command is issued until completion, the owning master sees the slave countdown unchanged (clamped values such as 3 included).
- R7: A master with no outstanding transaction sees a countdown of 0.
- R8: Read data of a completing read appears on the owner's read-data port in the cycle the countdown reaches 0. It is held there until that master's next read completes, and is unaffected by other masters' reads.
- R9: In the cycle a transaction completes, a new command, including one from the master just served, can be forwarded to the slave.
- R10: For a write, the address and write data reach the slave with the write strobe. The read and write strobes to the slave are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_rd | input | N_MST | Per-master one-cycle read strobe |
| m_wr | input | N_MST | Per-master one-cycle write strobe |
| m_addr | input | N_MST*AW | Per-master word address, master i at bits i*AW |
| m_wr_data | input | N_MST*DW | Per-master write data, master i at bits i*DW |
| m_rd_data | output | N_MST*DW | Per-master held read result |
| m_rdy_cnt | output | N_MST*2 | Per-master countdown: 3 waiting, slave value while owned, 0 idle |
| s_rd | output | 1 | Read strobe to the slave |
| s_wr | output | 1 | Write strobe to the slave |
| s_addr | output | AW | Address to the slave |
| s_wr_data | output | DW | Write data to the slave |
| s_rd_data | input | DW | Read data from the slave |
| s_rdy_cnt | input | 2 | Countdown from the slave |

## Verification
The sharpest overlap is completion of the current transaction in the same cycle that the next command is issued. In that cycle the finishing owner's data must be routed back while a new command, stored or live, goes out. The bench provokes this with a stored lower-priority command and a fresh higher-priority command both present at the completion cycle. It also has one master issue a new command in the very cycle its previous write completes. The bench judges the result by the slave address seen in that cycle, by the countdowns each master sees on the next cycles, and by each master's held read data afterwards.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int RDY_W = 2;
    localparam logic [RDY_W-1:0] RDY_WAIT = '1;
    localparam logic [RDY_W-1:0] RDY_DONE = '0;
endpackage

// File: rtl/arb_hold_slot.sv
module arb_hold_slot #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_rd,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          take,
    output logic          out_req,
    output logic          out_held,
    output logic          out_rd,
    output logic          out_wr,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_wdata
);
    typedef struct packed {
        logic          vld;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } slot_t;

    slot_t st_d, st_q;
    logic  live;

    assign live = in_rd | in_wr;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld = 1'b0;
        end else if (!st_q.vld && live) begin
            st_d.vld   = 1'b1;
            st_d.rd    = in_rd;
            st_d.addr  = in_addr;
            st_d.wdata = in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_req   = st_q.vld | live;
    assign out_held  = st_q.vld;
    assign out_rd    = st_q.vld ? st_q.rd    : in_rd;
    assign out_wr    = st_q.vld ? !st_q.rd   : (in_wr && !in_rd);
    assign out_addr  = st_q.vld ? st_q.addr  : in_addr;
    assign out_wdata = st_q.vld ? st_q.wdata : in_wdata;

    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !take) |=> (st_q.vld && $stable(st_q.addr) && $stable(st_q.rd)
                                 && $stable(st_q.wdata)));
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign gnt[i]    = en & req[i] & ~seen[i];
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) gnt_idx = IW'(i);
        end
    end

    assign any = |gnt;
endmodule

// File: rtl/arb_rd_hold.sv
module arb_rd_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] out_data
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap) data_d = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign out_data = cap ? in_data : data_q;

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> (cap || $stable(out_data)));
endmodule

// File: rtl/shared_slave_arbiter.sv
module shared_slave_arbiter #(
    parameter int N_MST = 3,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_MST-1:0]      m_rd,
    input  logic [N_MST-1:0]      m_wr,
    input  logic [N_MST*AW-1:0]   m_addr,
    input  logic [N_MST*DW-1:0]   m_wr_data,
    output logic [N_MST*DW-1:0]   m_rd_data,
    output logic [N_MST*2-1:0]    m_rdy_cnt,
    output logic                  s_rd,
    output logic                  s_wr,
    output logic [AW-1:0]         s_addr,
    output logic [DW-1:0]         s_wr_data,
    input  logic [DW-1:0]         s_rd_data,
    input  logic [1:0]            s_rdy_cnt
);
    import arb_pkg::*;

    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

    typedef struct packed {
        logic          busy;
        logic          rd;
        logic [IW-1:0] owner;
    } own_t;

    own_t own_d, own_q;

    logic [N_MST-1:0] req, held, gnt, cap, sl_rd, sl_wr;
    logic [AW-1:0]    sl_addr  [N_MST];
    logic [DW-1:0]    sl_wdata [N_MST];
    logic [IW-1:0]    gnt_idx;
    logic             any_gnt, free, done_now;

    assign free     = (s_rdy_cnt == RDY_DONE);
    assign done_now = own_q.busy && free;

    for (genvar i = 0; i < N_MST; i++) begin : g_port
        arb_hold_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_rd    (m_rd[i]),
            .in_wr    (m_wr[i]),
            .in_addr  (m_addr[i*AW +: AW]),
            .in_wdata (m_wr_data[i*DW +: DW]),
            .take     (gnt[i]),
            .out_req  (req[i]),
            .out_held (held[i]),
            .out_rd   (sl_rd[i]),
            .out_wr   (sl_wr[i]),
            .out_addr (sl_addr[i]),
            .out_wdata(sl_wdata[i])
        );

        assign cap[i] = done_now && own_q.rd && (own_q.owner == IW'(i));

        arb_rd_hold #(.DW(DW)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (cap[i]),
            .in_data (s_rd_data),
            .out_data(m_rd_data[i*DW +: DW])
        );

        assign m_rdy_cnt[i*2 +: 2] =
            held[i]                                     ? RDY_WAIT  :
            (own_q.busy && (own_q.owner == IW'(i)))     ? s_rdy_cnt :
                                                          RDY_DONE;
    end

    arb_prio_pick #(.N(N_MST), .IW(IW)) u_pick (
        .en     (free),
        .req    (req),
        .gnt    (gnt),
        .gnt_idx(gnt_idx),
        .any    (any_gnt)
    );

    always_comb begin
        s_rd      = 1'b0;
        s_wr      = 1'b0;
        s_addr    = '0;
        s_wr_data = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (gnt[i]) begin
                s_rd      = sl_rd[i];
                s_wr      = sl_wr[i];
                s_addr    = sl_addr[i];
                s_wr_data = sl_wdata[i];
            end
        end
    end

    always_comb begin
        own_d = own_q;
        if (done_now) own_d.busy = 1'b0;
        if (any_gnt) begin
            own_d.busy  = 1'b1;
            own_d.owner = gnt_idx;
            own_d.rd    = s_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own_d;
    end

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R3
    issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd || s_wr) |-> (s_rdy_cnt == RDY_DONE));
    // R4
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(held) <= N_MST - 1);
    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rd && s_wr));
endmodule

// File: tb/shared_slave_arbiter_test.sv
module shared_slave_arbiter_test;
    localparam int N  = 3;
    localparam int AW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      m_rd = '0, m_wr = '0;
    logic [N*AW-1:0]   m_addr = '0;
    logic [N*DW-1:0]   m_wr_data = '0;
    logic [N*DW-1:0]   m_rd_data;
    logic [N*2-1:0]    m_rdy_cnt;
    logic              s_rd, s_wr;
    logic [AW-1:0]     s_addr;
    logic [DW-1:0]     s_wr_data;
    logic [DW-1:0]     s_rd_data;
    logic [1:0]        s_rdy_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    shared_slave_arbiter #(.N_MST(N), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
        .m_wr_data(m_wr_data), .m_rd_data(m_rd_data), .m_rdy_cnt(m_rdy_cnt),
        .s_rd(s_rd), .s_wr(s_wr), .s_addr(s_addr), .s_wr_data(s_wr_data),
        .s_rd_data(s_rd_data), .s_rdy_cnt(s_rdy_cnt)
    );

    always #5 clk = ~clk;

    // slave model: countdown of lat cycles, result when it reaches 0
    int           lat = 2;
    int           cnt;
    logic         h_rd;
    logic [3:0]   h_a;
    logic [DW-1:0] h_d;
    logic [DW-1:0] mem [16];

    assign s_rdy_cnt = (cnt > 3) ? 2'd3 : 2'(cnt);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= 0;
            s_rd_data <= '0;
            for (int k = 0; k < 16; k++) mem[k] <= 32'hA000 + k;
        end else if (s_rd || s_wr) begin
            cnt  <= lat;
            h_rd <= s_rd;
            h_a  <= s_addr[3:0];
            h_d  <= s_wr_data;
            if (lat == 0) begin
                if (s_rd) s_rd_data <= mem[s_addr[3:0]];
                else      mem[s_addr[3:0]] <= s_wr_data;
            end
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                if (h_rd) s_rd_data <= mem[h_a];
                else      mem[h_a] <= h_d;
            end
        end
    end

    function automatic logic [1:0] rdy(int i);
        return m_rdy_cnt[i*2 +: 2];
    endfunction

    function automatic logic [DW-1:0] rdat(int i);
        return m_rd_data[i*DW +: DW];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(int i, bit rd, logic [AW-1:0] a, logic [DW-1:0] d);
        m_rd[i] = rd;
        m_wr[i] = !rd;
        m_addr[i*AW +: AW] = a;
        m_wr_data[i*DW +: DW] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        m_rd = '0;
        m_wr = '0;
        #1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin
            check("R1 rdy", 32'(rdy(i)), 0);
            check("R1 data", rdat(i), 0);
        end
        check("R1 strobes", {30'd0, s_rd, s_wr}, 0);
    endtask

    task automatic t_forward();
        lat = 2;
        put(1, 1, 8'd5, '0);
        #1;
        check("R2 same-cycle rd", 32'(s_rd), 1);
        check("R2 same-cycle addr", 32'(s_addr), 5);
        step();
        check("R6 owner rdy 2", 32'(rdy(1)), 2);
        check("R7 idle m0", 32'(rdy(0)), 0);
        check("R7 idle m2", 32'(rdy(2)), 0);
        step();
        check("R6 owner rdy 1", 32'(rdy(1)), 1);
        step();
        check("R6 owner rdy 0", 32'(rdy(1)), 0);
        check("R8 data at done", rdat(1), 32'hA005);
        step();
        check("R8 data held", rdat(1), 32'hA005);
    endtask

    task automatic t_write_back2back();
        lat = 1;
        put(2, 0, 8'd3, 32'h1234_5678);
        #1;
        check("R10 wr strobe", {30'd0, s_rd, s_wr}, 1);
        check("R10 wr addr", 32'(s_addr), 3);
        check("R10 wr data", s_wr_data, 32'h1234_5678);
        step();
        check("R6 wr rdy 1", 32'(rdy(2)), 1);
        step();
        check("R6 wr rdy 0", 32'(rdy(2)), 0);
        put(2, 1, 8'd3, '0);
        #1;
        check("R9 issue at completion", 32'(s_rd), 1);
        step();
        check("R6 rd rdy 1", 32'(rdy(2)), 1);
        step();
        check("R10 written value read", rdat(2), 32'h1234_5678);
    endtask

    task automatic t_contend();
        lat = 2;
        put(0, 1, 8'd1, '0);
        put(1, 1, 8'd2, '0);
        put(2, 1, 8'd4, '0);
        #1;
        check("R3 m0 wins", 32'(s_addr), 1);
        step();
        check("R6 m0 rdy", 32'(rdy(0)), 2);
        check("R5 m1 wait", 32'(rdy(1)), 3);
        check("R5 m2 wait", 32'(rdy(2)), 3);
        step();
        step();
        check("R8 m0 data", rdat(0), 32'hA001);
        check("R4 stored m1 issued", {31'd0, s_rd}, 1);
        check("R4 stored m1 addr", 32'(s_addr), 2);
        step();
        check("R6 m1 rdy", 32'(rdy(1)), 2);
        check("R5 m2 still wait", 32'(rdy(2)), 3);
        check("R7 m0 idle", 32'(rdy(0)), 0);
        step();
        step();
        check("R8 m1 data", rdat(1), 32'hA002);
        check("R4 stored m2 addr", 32'(s_addr), 4);
        step();
        step();
        step();
        check("R6 m2 done", 32'(rdy(2)), 0);
        check("R8 m2 data", rdat(2), 32'hA004);
        check("R8 m0 unaffected", rdat(0), 32'hA001);
    endtask

    task automatic t_live_over_stored();
        lat = 2;
        put(1, 1, 8'd7, '0);
        put(2, 1, 8'd6, '0);
        #1;
        check("R3 m1 over m2", 32'(s_addr), 7);
        step();
        step();
        step();
        check("R8 m1 data", rdat(1), 32'hA007);
        put(0, 1, 8'd8, '0);
        #1;
        check("R3 live m0 over stored m2", 32'(s_addr), 8);
        step();
        check("R5 m2 waits on", 32'(rdy(2)), 3);
        check("R6 m0 rdy", 32'(rdy(0)), 2);
        step();
        step();
        check("R8 m0 data", rdat(0), 32'hA008);
        check("R4 m2 issued late", 32'(s_addr), 6);
        step();
        step();
        step();
        check("R8 m2 data", rdat(2), 32'hA006);
        check("R8 m1 held", rdat(1), 32'hA007);
    endtask

    task automatic t_long();
        lat = 5;
        put(2, 1, 8'd9, '0);
        step();
        check("R6 clamp a", 32'(rdy(2)), 3);
        step();
        check("R6 clamp b", 32'(rdy(2)), 3);
        step();
        check("R6 clamp c", 32'(rdy(2)), 3);
        step();
        check("R6 rdy 2", 32'(rdy(2)), 2);
        check("R7 m0 idle", 32'(rdy(0)), 0);
        step();
        check("R6 rdy 1", 32'(rdy(2)), 1);
        step();
        check("R6 rdy 0", 32'(rdy(2)), 0);
        check("R8 long data", rdat(2), 32'hA009);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_forward();
        t_write_back2back();
        step();
        t_contend();
        step();
        t_live_over_stored();
        step();
        t_long();
        step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule